// File: doc/BRIEF.md
# Memory-Backed Read Burst Responder

This block answers read requests the way the slave side of an AXI4 read channel does. It keeps its own byte-addressed RAM. While it is idle it takes one request, made of a start address, a beat count and a beat size. It then streams that many data beats back under a valid/ready handshake. It marks the final beat and afterwards returns to waiting for the next request.

The start address may sit at any byte. Beat n covers the bytes from start + n·B up to, but not including, start + (n+1)·B, where B is the byte count of one beat. Addresses wrap modulo the RAM size. The RAM is built as one narrow bank per byte lane, so that each lane maps onto a block RAM and an unaligned window can be read in a single cycle. A testbench or loader fills the RAM through a one-byte write port, and only while no burst is running. The block supports a single outstanding burst, incrementing addresses only, and always answers OKAY.

Top module: `rd_burst_server`

## Requirements
- R1: After reset, rq_ready is 1 and rs_valid and rs_last are 0.
- R2: rq_ready is 1 only while no burst is active. A request is taken on an edge where rq_valid and rq_ready are both 1. While a burst runs, rq_ready stays 0 and rq_valid is ignored.
- R3: A request with length field L returns exactly L+1 beats.
- R4: Let B = 2^rq_size, capped at DATA_W/8. Byte lane i of rs_data (bits 8i+7..8i) carries the RAM byte at (beat address + i) for i < B. Lanes at i >= B are zero.
- R5: The beat address of beat n is start + n·B, taken modulo the RAM size. The start address need not be aligned.
- R6: rs_valid first rises on the second clock edge after the request is taken. It then stays 1 until the final beat is accepted.
- R7: A beat is consumed only on an edge where rs_ready is 1. Otherwise the same rs_data and rs_last are presented again.
- R8: rs_last is 1 only while the final beat is presented. After that beat is accepted, rs_valid drops and rq_ready returns on the same edge.
- R9: rs_resp is always 2'b00 (OKAY).
- R10: rq_burst and rq_prot have no effect on the returned data. FIXED (0) and WRAP (2) behave as INCR (1).
- R11: When ld_we is 1 at an edge, ld_byte is written to RAM byte ld_addr. Later bursts return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Preload byte write enable |
| ld_addr | input | ADDR_W | Preload byte address |
| ld_byte | input | 8 | Preload byte value |
| rq_valid | input | 1 | Request valid |
| rq_ready | output | 1 | Request ready (idle) |
| rq_addr | input | ADDR_W | Start byte address |
| rq_len | input | 8 | Beat count minus one |
| rq_size | input | 3 | log2 of bytes per beat |
| rq_burst | input | 2 | Burst kind (treated as incrementing) |
| rq_prot | input | 3 | Protection attributes (ignored) |
| rs_valid | output | 1 | Read beat valid |
| rs_ready | input | 1 | Read beat accepted |
| rs_data | output | DATA_W | Beat data, low lanes first |
| rs_resp | output | 2 | Response code, always OKAY |
| rs_last | output | 1 | Final beat of the burst |

## Verification
Bursts are run with aligned and unaligned starts, which shows whether the lane rotation across banks is right. They also use byte, half-word, full-word and oversized beats, which separates address stepping from lane masking. A burst that crosses the top of the RAM checks the address wrap. Single-beat and eight-beat bursts check the beat count and where rs_last falls. A toggling rs_ready shows whether a stalled beat is held or skipped. A request held high during a burst, odd burst kinds and protection values, and a rewrite of RAM bytes show which inputs actually steer the output.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SEND  = 2'd2
  } rdb_state_e;

  typedef struct packed {
    logic [7:0] len;
    logic [1:0] kind;
    logic [2:0] prot;
  } rdb_req_t;

  // Cap the requested size at the width of the data bus.
  function automatic logic [2:0] cap_size(input logic [2:0] sz, input int lg_max);
    return (int'(sz) > lg_max) ? 3'(lg_max) : sz;
  endfunction

endpackage

// File: rtl/rdb_bank_ram.sv
module rdb_bank_ram #(
  parameter int ADDR_W = 10,
  parameter int LG_NB  = 2
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [7:0]             wr_byte,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [8*(2**LG_NB)-1:0] rd_lanes
);
  localparam int NB    = 2 ** LG_NB;
  localparam int ROW_W = ADDR_W - LG_NB;
  localparam int ROWS  = 2 ** ROW_W;

  logic [7:0]       bank_q [NB];
  logic [LG_NB-1:0] off_q;

  always_ff @(posedge clk) begin
    off_q <= rd_addr[LG_NB-1:0];
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [7:0]        mem [ROWS];
    logic [LG_NB-1:0]  lane_of_bank;
    logic [ADDR_W-1:0] byte_addr;
    logic [ROW_W-1:0]  row;

    // Lane served by this bank, then the byte address it must fetch.
    assign lane_of_bank = LG_NB'(b) - rd_addr[LG_NB-1:0];
    assign byte_addr    = rd_addr + ADDR_W'(lane_of_bank);
    assign row          = byte_addr[ADDR_W-1:LG_NB];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr[LG_NB-1:0] == LG_NB'(b))) begin
        mem[wr_addr[ADDR_W-1:LG_NB]] <= wr_byte;
      end
      bank_q[b] <= mem[row];
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [LG_NB-1:0] sel;
    assign sel = off_q + LG_NB'(i);
    assign rd_lanes[8*i +: 8] = bank_q[sel];
  end

endmodule

// File: rtl/rdb_ctrl.sv
module rdb_ctrl
  import rdb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LG_NB  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rq_valid,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [7:0]        rq_len,
  input  logic [2:0]        rq_size,
  input  logic [1:0]        rq_burst,
  input  logic [2:0]        rq_prot,
  output logic              rq_ready,
  input  logic              rs_ready,
  output logic              rs_valid,
  output logic              rs_last,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        beat_lg
);
  rdb_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [8:0]        remain;
  rdb_req_t          req;
  logic [ADDR_W-1:0] step;
  logic              take;

  assign step = ADDR_W'(1) << beat_lg;
  assign take = (state == ST_SEND) && rs_ready;

  // Address presented to the RAM for the data shown in the next cycle.
  always_comb begin
    if (state == ST_IDLE)  rd_addr = rq_addr;
    else if (take)         rd_addr = cur_addr + step;
    else                   rd_addr = cur_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      beat_lg  <= '0;
      req      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rq_valid) begin
          cur_addr <= rq_addr;
          remain   <= {1'b0, rq_len} + 9'd1;
          beat_lg  <= cap_size(rq_size, LG_NB);
          req      <= '{len: rq_len, kind: rq_burst, prot: rq_prot};
          state    <= ST_FETCH;
        end
        ST_FETCH: state <= ST_SEND;
        ST_SEND: if (rs_ready) begin
          cur_addr <= cur_addr + step;
          remain   <= remain - 9'd1;
          if (remain == 9'd1) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rq_ready = (state == ST_IDLE);
  assign rs_valid = (state == ST_SEND);
  assign rs_last  = (state == ST_SEND) && (remain == 9'd1);

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (rst)
    rq_ready |-> !rs_valid);
  assert_valid_held_R6: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !(rs_ready && rs_last)) |=> rs_valid);
  assert_fetch_then_send_R6: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && rq_ready) |=> (!rs_valid && !rq_ready) ##1 rs_valid);
  assert_last_ends_R8: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_ready && rs_last) |=> (!rs_valid && rq_ready));
  assert_last_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
    rs_last |-> rs_valid);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && $past(rs_valid)) |-> $stable(req));

endmodule

// File: rtl/rd_burst_server.sv
module rd_burst_server #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_byte,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [7:0]        rq_len,
  input  logic [2:0]        rq_size,
  input  logic [1:0]        rq_burst,
  input  logic [2:0]        rq_prot,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [DATA_W-1:0] rs_data,
  output logic [1:0]        rs_resp,
  output logic              rs_last
);
  localparam int NB    = DATA_W / 8;
  localparam int LG_NB = $clog2(NB);

  logic [ADDR_W-1:0] rd_addr;
  logic [2:0]        beat_lg;
  logic [DATA_W-1:0] lanes;

  rdb_ctrl #(.ADDR_W(ADDR_W), .LG_NB(LG_NB)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rq_valid (rq_valid),
    .rq_addr  (rq_addr),
    .rq_len   (rq_len),
    .rq_size  (rq_size),
    .rq_burst (rq_burst),
    .rq_prot  (rq_prot),
    .rq_ready (rq_ready),
    .rs_ready (rs_ready),
    .rs_valid (rs_valid),
    .rs_last  (rs_last),
    .rd_addr  (rd_addr),
    .beat_lg  (beat_lg)
  );

  rdb_bank_ram #(.ADDR_W(ADDR_W), .LG_NB(LG_NB)) u_ram (
    .clk      (clk),
    .wr_en    (ld_we),
    .wr_addr  (ld_addr),
    .wr_byte  (ld_byte),
    .rd_addr  (rd_addr),
    .rd_lanes (lanes)
  );

  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign rs_data[8*i +: 8] = (32'(i) < (32'd1 << beat_lg)) ? lanes[8*i +: 8] : 8'h00;
  end

  assign rs_resp = 2'b00;

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_ready && !ld_we) |=> (rs_valid && $stable(rs_data) && $stable(rs_last)));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |-> !rs_last);

endmodule

// File: tb/test_rd_burst_server.sv
module test_rd_burst_server;
  localparam int PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam int MSZ = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_byte = '0;
  logic          rq_valid = 1'b0;
  logic          rq_ready;
  logic [AW-1:0] rq_addr = '0;
  logic [7:0]    rq_len = '0;
  logic [2:0]    rq_size = '0;
  logic [1:0]    rq_burst = 2'd1;
  logic [2:0]    rq_prot = '0;
  logic          rs_valid;
  logic          rs_ready = 1'b0;
  logic [DW-1:0] rs_data;
  logic [1:0]    rs_resp;
  logic          rs_last;

  logic [7:0] ref_mem [MSZ];
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  rd_burst_server #(.DATA_W(DW), .ADDR_W(AW)) i_rd_burst_server (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_byte(ld_byte),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_len(rq_len),
    .rq_size(rq_size), .rq_burst(rq_burst), .rq_prot(rq_prot),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data),
    .rs_resp(rs_resp), .rs_last(rs_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(input int a, input int n, input int bpb);
    logic [DW-1:0] w = '0;
    for (int i = 0; i < bpb; i++) w[8*i +: 8] = ref_mem[(a + n*bpb + i) % MSZ];
    return w;
  endfunction

  task automatic load_byte(input int a, input logic [7:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(a); ld_byte = v;
    ref_mem[a] = v;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // stall: 0 = always ready, 1 = ready every other cycle, 2 = two idle cycles then ready
  task automatic run_burst(input int a, input int len, input int sz, input int kind,
                           input int prot, input int stall, input bit hold_req, input string tag);
    int bpb = 1 << ((sz > 2) ? 2 : sz);
    int n = 0;
    int cyc = 0;
    bit prev_stall = 1'b0;
    logic [DW-1:0] prev_data = '0;
    @(negedge clk);
    chk(rq_ready == 1'b1, {"R2 idle ready ", tag}, rq_ready, 1);
    rq_valid = 1'b1; rq_addr = AW'(a); rq_len = 8'(len); rq_size = 3'(sz);
    rq_burst = 2'(kind); rq_prot = 3'(prot); rs_ready = 1'b0;
    @(negedge clk);
    if (hold_req) rq_addr = AW'(a + 100); else rq_valid = 1'b0;
    chk(rs_valid == 1'b0, {"R6 no data in fetch cycle ", tag}, rs_valid, 0);
    chk(rq_ready == 1'b0, {"R2 busy after accept ", tag}, rq_ready, 0);
    @(negedge clk);
    while (n <= len && cyc < 4000) begin
      bit r;
      r = (stall == 0) ? 1'b1 : (stall == 1) ? bit'(cyc % 2) : bit'(cyc % 3 == 2);
      chk(rs_valid == 1'b1, {"R6 valid held ", tag}, rs_valid, 1);
      chk(rq_ready == 1'b0, {"R2 no request taken mid-burst ", tag}, rq_ready, 0);
      chk(rs_data == exp_word(a, n, bpb), {"R4 R5 beat data ", tag}, rs_data, exp_word(a, n, bpb));
      chk(rs_last == (n == len), {"R3 R8 last flag ", tag}, rs_last, (n == len));
      chk(rs_resp == 2'b00, {"R9 response ", tag}, rs_resp, 0);
      if (prev_stall) chk(rs_data == prev_data, {"R7 stalled beat repeated ", tag}, rs_data, prev_data);
      prev_stall = !r;
      prev_data = rs_data;
      rs_ready = r;
      @(negedge clk);
      if (r) n++;
      cyc++;
    end
    rq_valid = 1'b0;
    rs_ready = 1'b0;
    chk(rs_valid == 1'b0, {"R8 valid drops after last ", tag}, rs_valid, 0);
    chk(rq_ready == 1'b1, {"R8 ready returns ", tag}, rq_ready, 1);
    chk(rs_last == 1'b0, {"R8 last clears ", tag}, rs_last, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rq_ready == 1'b1, "R1 rq_ready after reset", rq_ready, 1);
    chk(rs_valid == 1'b0, "R1 rs_valid after reset", rs_valid, 0);
    chk(rs_last == 1'b0, "R1 rs_last after reset", rs_last, 0);
  endtask

  task automatic t_single;      run_burst(16, 0, 2, 1, 0, 0, 0, "R3 single beat"); endtask
  task automatic t_eight;       run_burst(64, 7, 2, 1, 0, 0, 0, "R3 eight beats"); endtask
  task automatic t_unaligned;   run_burst(19, 3, 2, 1, 0, 0, 0, "R5 unaligned word"); endtask
  task automatic t_bytes;       run_burst(200, 5, 0, 1, 0, 0, 0, "R4 byte beats"); endtask
  task automatic t_halves;      run_burst(33, 3, 1, 1, 0, 0, 0, "R4 half beats"); endtask
  task automatic t_oversize;    run_burst(300, 2, 5, 1, 0, 0, 0, "R4 size capped"); endtask
  task automatic t_stall;       run_burst(401, 4, 2, 1, 0, 1, 0, "R7 alternate ready");
                                run_burst(77, 3, 1, 1, 0, 2, 0, "R7 long stalls"); endtask
  task automatic t_kinds;       run_burst(500, 3, 2, 0, 7, 0, 0, "R10 fixed kind");
                                run_burst(500, 3, 2, 2, 5, 1, 0, "R10 wrap kind"); endtask
  task automatic t_wrap_top;    run_burst(MSZ - 5, 3, 2, 1, 0, 0, 0, "R5 wrap at top"); endtask
  task automatic t_held_req;    run_burst(600, 4, 2, 1, 0, 1, 1, "R2 request held"); endtask

  task automatic t_preload;
    load_byte(700, 8'hA5); load_byte(701, 8'h5A);
    load_byte(702, 8'hC3); load_byte(703, 8'h3C);
    run_burst(700, 0, 2, 1, 0, 0, 0, "R11 rewritten bytes");
  endtask

  initial begin
    for (int a = 0; a < MSZ; a++) ref_mem[a] = 8'((a * 37 + 11) ^ (a >> 5));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    for (int a = 0; a < MSZ; a++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(a); ld_byte = ref_mem[a];
    end
    @(negedge clk);
    ld_we = 1'b0;
    t_single();
    t_eight();
    t_unaligned();
    t_bytes();
    t_halves();
    t_oversize();
    t_stall();
    t_kinds();
    t_wrap_top();
    t_held_req();
    t_preload();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule